// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Port

This block is a half-duplex synchronous serial port. It moves bytes over one bidirectional data pin and drives a shift clock on a second pin. Transfers run at one bit per machine cycle. A machine cycle lasts a fixed number of system clocks, 12 by default. The host writes a byte to start a transmit. It starts a receive by raising the enable input while the receive-done flag is clear. A single buffer register holds the byte last written by the host or the byte last received, and it is always visible on the read-data port.

Neither direction uses a bit counter. The transmit shifter is one bit wider than the data, and a 1 loaded into its top bit marks the end of the byte. The transfer ends when that marker arrives just above the output bit. The receive shifter is preloaded with all ones plus a single 0 at the far end. The transfer ends when the 0 reaches the output end. When the port is idle, the shift clock rests high and the data pin is released as an input.

Top module: `sync_serial_port`

## Requirements
- R1: While rst_ni is low, tx_done_o and rx_done_o are 0, sdata_oe_o is 0, sclk_o is 1 and rd_data_o is 0.
- R2: An accepted host write copies wdata_i into rd_data_o. It then sends the byte on sdata_o least significant bit first, one bit per shift-clock period, with sdata_oe_o high for every bit.
- R3: Transmit begins at the first machine-cycle boundary after the write, within 12 system clocks. tx_done_o rises exactly 8 machine cycles (96 clocks) after the first falling edge of sclk_o.
- R4: Each transferred bit produces exactly one shift-clock pulse: low for the first half of the machine cycle and high for the second half. A byte gives 8 rising edges.
- R5: tx_done_o and rx_done_o stay at 1 until the matching clear input is pulsed.
- R6: A host write that arrives while a transmit is pending or in progress is ignored. The bits on the pin and rd_data_o are unchanged.
- R7: A receive starts only when rx_en_i is 1 and rx_done_o is 0. If either condition is missing, sclk_o stays high and rd_data_o keeps its value.
- R8: During a receive, sdata_i is sampled on each rising edge of sclk_o, first bit into bit 0. After 8 bits the byte appears on rd_data_o, rx_done_o is set and sdata_oe_o stays 0 throughout.
- R9: When no transfer is active, sclk_o is 1 and sdata_oe_o is 0.
- R10: A byte sent and then fed back bit for bit into the receiver comes back unchanged, for every byte value 0 to 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | Host write strobe for the buffer register |
| wdata_i | input | 8 | Host write data |
| rd_data_o | output | 8 | Buffer register contents |
| rx_en_i | input | 1 | Receive enable |
| clr_tx_done_i | input | 1 | Clears the transmit-done flag |
| clr_rx_done_i | input | 1 | Clears the receive-done flag |
| tx_done_o | output | 1 | Transmit-done flag |
| rx_done_o | output | 1 | Receive-done flag |
| sdata_o | output | 1 | Data pin output value |
| sdata_oe_o | output | 1 | Data pin output enable |
| sdata_i | input | 1 | Data pin input value |
| sclk_o | output | 1 | Shift clock |

## Verification
Transmit is tried with single-bit, nibble, palindromic and asymmetric bytes. Reading them back in wire order separates LSB-first from MSB-first shifting and shows whether the marker ends the transfer too early or too late. Receive is fed a byte whose halves differ, which exposes a wrong sample edge or a reversed fill direction. A full loopback over all 256 values compares both shifters against each other. Directed cases cover a write landing in the middle of a transmit, and an enable held high while the done flag is still set.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int unsigned SSP_MC_CLKS = 12;
  localparam int unsigned SSP_DATA_W  = 8;
endpackage

// File: rtl/ssp_timebase.sv
module ssp_timebase #(
  parameter int unsigned MC_CLKS = ssp_pkg::SSP_MC_CLKS
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic mc_end_o,
  output logic smp_o,
  output logic low_o
);
  localparam int unsigned PW   = $clog2(MC_CLKS);
  localparam int unsigned HALF = MC_CLKS / 2;

  logic [PW-1:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        ph_q <= '0;
    else if (ph_q == PW'(MC_CLKS - 1))  ph_q <= '0;
    else                                ph_q <= ph_q + 1'b1;
  end

  assign mc_end_o = (ph_q == PW'(MC_CLKS - 1));
  assign smp_o    = (ph_q == PW'(HALF - 1));  // clock edge where sclk rises
  assign low_o    = (ph_q < PW'(HALF));

  p_phase_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_q < PW'(MC_CLKS));
endmodule

// File: rtl/ssp_tx.sv
module ssp_tx #(
  parameter int unsigned W = ssp_pkg::SSP_DATA_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         mc_end_i,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         clr_i,
  output logic         busy_o,
  output logic         send_o,
  output logic         bit_o,
  output logic         done_o
);
  logic [W:0] sh_q;   // top bit is the end marker
  logic       pend_q, send_q, done_q;
  logic       last;

  assign last = send_q && (sh_q[W:1] == W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      pend_q <= 1'b0;
      send_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (load_i) begin
        sh_q   <= {1'b1, data_i};
        pend_q <= 1'b1;
      end
      if (mc_end_i && pend_q) begin
        send_q <= 1'b1;
        pend_q <= 1'b0;
      end
      if (mc_end_i && send_q) begin
        sh_q <= {1'b0, sh_q[W:1]};
        if (last) send_q <= 1'b0;
      end
      if (mc_end_i && last) done_q <= 1'b1;
      else if (clr_i)       done_q <= 1'b0;
    end
  end

  assign busy_o = pend_q | send_q;
  assign send_o = send_q;
  assign bit_o  = sh_q[0];
  assign done_o = done_q;

  p_marker_live_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    send_q |-> (sh_q != '0));
  p_start_on_mc_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(send_q) |-> $past(mc_end_i));
  p_load_when_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (!send_q && !pend_q));
  p_tx_done_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !clr_i) |=> done_q);
endmodule

// File: rtl/ssp_rx.sv
module ssp_rx #(
  parameter int unsigned W = ssp_pkg::SSP_DATA_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         mc_end_i,
  input  logic         smp_i,
  input  logic         en_i,
  input  logic         blocked_i,
  input  logic         clr_i,
  input  logic         pin_i,
  output logic         busy_o,
  output logic         recv_o,
  output logic         done_o,
  output logic         valid_o,
  output logic [W-1:0] data_o
);
  localparam logic [W-1:0] SENT = {1'b0, {(W-1){1'b1}}};

  logic [W-1:0] sh_q;
  logic         arm_q, recv_q, done_q, bit_q;
  logic         start_ok;

  assign start_ok = en_i && !done_q && !recv_q && !blocked_i;
  assign data_o   = {bit_q, sh_q[W-1:1]};
  assign valid_o  = mc_end_i && recv_q && !sh_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      arm_q  <= 1'b0;
      recv_q <= 1'b0;
      done_q <= 1'b0;
      bit_q  <= 1'b1;
    end else begin
      arm_q <= start_ok;
      if (mc_end_i && arm_q && start_ok) begin
        recv_q <= 1'b1;
        sh_q   <= SENT;
      end
      if (smp_i && recv_q) bit_q <= pin_i;
      if (mc_end_i && recv_q) begin
        sh_q <= data_o;
        if (!sh_q[0]) recv_q <= 1'b0;  // sentinel reached the end
      end
      if (valid_o)    done_q <= 1'b1;
      else if (clr_i) done_q <= 1'b0;
    end
  end

  assign busy_o = arm_q | recv_q;
  assign recv_o = recv_q;
  assign done_o = done_q;

  p_rx_preload_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(recv_q) |-> (sh_q == SENT));
  p_rx_start_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(recv_q) |-> ($past(en_i) && !$past(done_q)));
  p_rx_done_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !clr_i) |=> done_q);
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port #(
  parameter int unsigned MC_CLKS = ssp_pkg::SSP_MC_CLKS,
  parameter int unsigned W       = ssp_pkg::SSP_DATA_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rd_data_o,
  input  logic         rx_en_i,
  input  logic         clr_tx_done_i,
  input  logic         clr_rx_done_i,
  output logic         tx_done_o,
  output logic         rx_done_o,
  output logic         sdata_o,
  output logic         sdata_oe_o,
  input  logic         sdata_i,
  output logic         sclk_o
);
  logic         mc_end, smp, low;
  logic         tx_busy, tx_send, tx_bit;
  logic         rx_busy, rx_recv, rx_valid;
  logic [W-1:0] rx_data, buf_q;
  logic         wr_ok;

  assign wr_ok = wr_i && !tx_busy && !rx_busy;

  ssp_timebase #(.MC_CLKS(MC_CLKS)) u_tb (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .mc_end_o(mc_end), .smp_o(smp), .low_o(low));

  ssp_tx #(.W(W)) u_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .mc_end_i(mc_end),
    .load_i(wr_ok), .data_i(wdata_i), .clr_i(clr_tx_done_i),
    .busy_o(tx_busy), .send_o(tx_send), .bit_o(tx_bit), .done_o(tx_done_o));

  ssp_rx #(.W(W)) u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .mc_end_i(mc_end), .smp_i(smp),
    .en_i(rx_en_i), .blocked_i(tx_busy), .clr_i(clr_rx_done_i),
    .pin_i(sdata_i), .busy_o(rx_busy), .recv_o(rx_recv),
    .done_o(rx_done_o), .valid_o(rx_valid), .data_o(rx_data));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       buf_q <= '0;
    else if (wr_ok)    buf_q <= wdata_i;
    else if (rx_valid) buf_q <= rx_data;
  end

  assign rd_data_o  = buf_q;
  assign sdata_o    = tx_bit;
  assign sdata_oe_o = tx_send;
  assign sclk_o     = !(low && (tx_send || rx_recv));

  p_half_duplex_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_send && rx_recv));
  p_idle_clk_high_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_busy && !rx_busy) |-> sclk_o);
  p_rx_pin_released_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_recv |-> !sdata_oe_o);
endmodule

// File: tb/sim_sync_serial_port.sv
`timescale 1ns/1ps
module sim_sync_serial_port;
  localparam int CLK_PERIOD = 10;
  // {data, expected wire order with first bit in bit 7}
  localparam logic [15:0] VEC [6] = '{16'h01_80, 16'h0F_F0, 16'hA5_A5,
                                      16'h3C_3C, 16'h80_01, 16'hC1_83};

  logic clk_i = 0, rst_ni = 0, wr_i = 0, rx_en_i = 0;
  logic clr_tx_done_i = 0, clr_rx_done_i = 0, sdata_i = 1;
  logic [7:0] wdata_i = 0;
  logic [7:0] rd_data_o;
  logic tx_done_o, rx_done_o, sdata_o, sdata_oe_o, sclk_o;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  sync_serial_port u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .wdata_i(wdata_i),
    .rd_data_o(rd_data_o), .rx_en_i(rx_en_i), .clr_tx_done_i(clr_tx_done_i),
    .clr_rx_done_i(clr_rx_done_i), .tx_done_o(tx_done_o), .rx_done_o(rx_done_o),
    .sdata_o(sdata_o), .sdata_oe_o(sdata_oe_o), .sdata_i(sdata_i), .sclk_o(sclk_o));

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_tx(input logic [7:0] d, input bit ovr, input logic [7:0] od,
                        output logic [7:0] got, output int nb, output int t0,
                        output int dur, output bit oe_bad);
    int cyc;
    bit prev;
    got = 0; nb = 0; t0 = -1; dur = -1; oe_bad = 0; cyc = 0;
    @(negedge clk_i); wr_i = 1; wdata_i = d; clr_tx_done_i = 1;
    @(negedge clk_i); wr_i = 0; clr_tx_done_i = 0;
    prev = sclk_o;
    for (int k = 0; k < 400; k++) begin
      @(posedge clk_i); #1;
      cyc++;
      wr_i = 0;
      if (prev && !sclk_o && t0 < 0) t0 = cyc;
      if (!prev && sclk_o) begin
        if (nb < 8) got[nb] = sdata_o;
        if (!sdata_oe_o) oe_bad = 1;
        nb++;
        if (ovr && nb == 3) begin wr_i = 1; wdata_i = od; end
      end
      prev = sclk_o;
      if (tx_done_o) begin dur = cyc - t0; break; end
    end
  endtask

  task automatic run_rx(input logic [7:0] d, output int nf, output bit oe_bad);
    bit prev;
    nf = 0; oe_bad = 0;
    @(negedge clk_i); rx_en_i = 1; clr_rx_done_i = 1;
    @(negedge clk_i); clr_rx_done_i = 0;
    prev = sclk_o;
    for (int k = 0; k < 500; k++) begin
      @(posedge clk_i); #1;
      if (sdata_oe_o) oe_bad = 1;
      if (prev && !sclk_o) begin
        sdata_i = (nf < 8) ? d[nf] : 1'b1;
        nf++;
      end
      prev = sclk_o;
      if (rx_done_o) break;
    end
    rx_en_i = 0; sdata_i = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] got, rev, hold;
    int nb, t0, dur, nf;
    bit oe_bad, clk_low;

    #(3*CLK_PERIOD + 2);
    chk(!tx_done_o && !rx_done_o, "R1 flags", {tx_done_o, rx_done_o}, 0);
    chk(!sdata_oe_o && sclk_o, "R1 pins", {sdata_oe_o, sclk_o}, 1);
    chk(rd_data_o == 0, "R1 buffer", rd_data_o, 0);
    @(negedge clk_i); rst_ni = 1;

    repeat (30) @(posedge clk_i);
    #1;
    chk(sclk_o && !sdata_oe_o, "R9 idle", {sclk_o, sdata_oe_o}, 2);

    foreach (VEC[i]) begin
      run_tx(VEC[i][15:8], 0, 0, got, nb, t0, dur, oe_bad);
      for (int b = 0; b < 8; b++) rev[7-b] = got[b];
      chk(rev == VEC[i][7:0], "R2 wire order", rev, VEC[i][7:0]);
      chk(!oe_bad, "R2 oe during bits", oe_bad, 0);
      chk(rd_data_o == VEC[i][15:8], "R2 buffer load", rd_data_o, VEC[i][15:8]);
      chk(t0 >= 1 && t0 <= 12, "R3 start latency", t0, 12);
      chk(dur == 96, "R3 duration", dur, 96);
      chk(nb == 8, "R4 pulse count", nb, 8);
    end

    // R4: one low half then one high half per bit
    @(negedge clk_i); wr_i = 1; wdata_i = 8'h55; clr_tx_done_i = 1;
    @(negedge clk_i); wr_i = 0; clr_tx_done_i = 0;
    while (sclk_o) @(negedge clk_i);
    nb = 0;
    while (!sclk_o) begin nb++; @(negedge clk_i); end
    chk(nb == 6, "R4 low half", nb, 6);
    nb = 0;
    while (sclk_o && !tx_done_o) begin nb++; @(negedge clk_i); end
    chk(nb == 6, "R4 high half", nb, 6);
    while (!tx_done_o) @(negedge clk_i);

    // R5 sticky transmit flag
    repeat (30) @(negedge clk_i);
    chk(tx_done_o, "R5 tx_done held", tx_done_o, 1);
    clr_tx_done_i = 1; @(negedge clk_i); clr_tx_done_i = 0;
    chk(!tx_done_o, "R5 tx_done cleared", tx_done_o, 0);

    // R6 write during transmit ignored
    run_tx(8'h5A, 1, 8'hFF, got, nb, t0, dur, oe_bad);
    chk(got == 8'h5A, "R6 bits unchanged", got, 8'h5A);
    chk(rd_data_o == 8'h5A, "R6 buffer unchanged", rd_data_o, 8'h5A);

    // R8 receive
    run_rx(8'h96, nf, oe_bad);
    chk(rd_data_o == 8'h96, "R8 received byte", rd_data_o, 8'h96);
    chk(nf == 8, "R8 bit count", nf, 8);
    chk(rx_done_o, "R8 rx_done", rx_done_o, 1);
    chk(!oe_bad, "R8 pin released", oe_bad, 0);

    // R7 no restart while done set, none while disabled; R5 sticky receive flag
    hold = rd_data_o;
    clk_low = 0;
    @(negedge clk_i); rx_en_i = 1; sdata_i = 0;
    for (int k = 0; k < 60; k++) begin @(negedge clk_i); if (!sclk_o) clk_low = 1; end
    chk(!clk_low, "R7 blocked by done", clk_low, 0);
    chk(rx_done_o, "R5 rx_done held", rx_done_o, 1);
    chk(rd_data_o == hold, "R7 buffer kept", rd_data_o, hold);
    rx_en_i = 0; clr_rx_done_i = 1; @(negedge clk_i); clr_rx_done_i = 0;
    chk(!rx_done_o, "R5 rx_done cleared", rx_done_o, 0);
    for (int k = 0; k < 60; k++) begin @(negedge clk_i); if (!sclk_o) clk_low = 1; end
    chk(!clk_low, "R7 blocked by disable", clk_low, 0);
    chk(rd_data_o == hold, "R7 buffer kept disabled", rd_data_o, hold);
    sdata_i = 1;

    // R10 loopback of every byte value
    for (int v = 0; v < 256; v++) begin
      run_tx(8'(v), 0, 0, got, nb, t0, dur, oe_bad);
      @(negedge clk_i); wdata_i = 8'h00;
      run_rx(got, nf, oe_bad);
      chk(rd_data_o == 8'(v), "R10 loopback", rd_data_o, v);
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule